// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block keeps the program counter and the stack pointer of a small 8-bit processor core and works out the next program counter on every clock. A decoder sends it one command per cycle. The command either holds the program counter, steps it by the current instruction length, jumps (long, in-page or relative), or vectors to an interrupt routine. Two more commands push the accumulator to the stack or pop a byte back from the stack.

The stack lives in an external synchronous RAM. The block drives that RAM's address, write data and write strobe from registers. The RAM returns read data one cycle after it sees an address. Popped bytes come back to the core on a separate data output with a one-cycle valid strobe. The stack grows toward lower addresses. A push stores the byte and then moves the pointer down. A pop moves the pointer up and then reads.

A relative displacement outside the legal window is not executed. It is reported on a one-cycle flag, and the program counter steps on instead.

Top module: `pc_stack_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `pc` is 0, `sp` is 0x6F, and `stk_we`, `pop_valid` and `bad_disp` are 0.
- R2: Command codes on `cmd` are: 0 hold, 1 step, 2 long jump, 3 page jump, 4 relative jump, 5 vector, 6 push, 7 pop. Hold leaves `pc` and `sp` unchanged. Step adds `instr_len` (1 to 3) to `pc`, modulo 2^15. All outputs change at the clock edge that samples the command.
- R3: A long jump loads all 15 bits of `jmp_imm` into `pc`.
- R4: A page jump replaces `pc[11:0]` with `jmp_imm[11:0]` and keeps `pc[14:12]`.
- R5: A relative jump adds `disp`, read as a 7-bit two's-complement value, to `pc` modulo 2^15. This applies when `disp` lies in -31..+32 and is not +1.
- R6: A relative jump whose `disp` is +1 or lies outside -31..+32 raises `bad_disp` for one cycle and adds `instr_len` to `pc` instead.
- R7: A vector command loads `pc` with `{vec_hi[6:0], vec_lo}`.
- R8: A push writes `acc_in` to stack address `sp`. It sets `stk_we` for one cycle with `stk_addr` = old `sp` and `stk_wdata` = `acc_in`. It then sets `sp` to old `sp` - 1 and adds `instr_len` to `pc`.
- R9: A pop sets `sp` and `stk_addr` to old `sp` + 1, keeps `stk_we` low, and adds `instr_len` to `pc`. Three edges after the pop is sampled, `pop_valid` is high for one cycle. At that point `pop_data` equals `mem_rdata` as presented in the cycle before.
- R10: `sp` wraps modulo 256 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code for this cycle |
| instr_len | input | 2 | Length in bytes of the current instruction |
| jmp_imm | input | 15 | Jump target (long) or in-page offset (low 12 bits) |
| disp | input | 7 | Signed relative-jump displacement |
| vec_hi | input | 8 | Vector table byte for the upper PC |
| vec_lo | input | 8 | Vector table byte for the lower PC |
| acc_in | input | 8 | Accumulator value to push |
| mem_rdata | input | 8 | Stack RAM read data (one-cycle latency) |
| pc | output | 15 | Program counter |
| sp | output | 8 | Stack pointer |
| stk_addr | output | 8 | Stack RAM address |
| stk_wdata | output | 8 | Stack RAM write data |
| stk_we | output | 1 | Stack RAM write enable |
| pop_data | output | 8 | Byte returned by a pop |
| pop_valid | output | 1 | Strobe marking `pop_data` valid |
| bad_disp | output | 1 | Illegal relative displacement seen |

## Verification
Properties are checked on every cycle for the following:
- hold stability;
- the long, page and vector loads;
- the pointer step and address on push and pop;
- the three-edge pop return;
- the program-counter step that replaces a rejected displacement.

The bench scenarios cover the rest. These include the full displacement window with its edge values -31 and +32, the holes at +1, +33 and -32, and wrap of the program counter in both directions. The bench also walks the stack pointer through 0xFF to 0x00 and back. Finally, it checks that a pop returns the value of an earlier push through a modelled RAM.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    CMD_HOLD  = 3'd0,
    CMD_STEP  = 3'd1,
    CMD_JLONG = 3'd2,
    CMD_JPAGE = 3'd3,
    CMD_JREL  = 3'd4,
    CMD_VECT  = 3'd5,
    CMD_PUSH  = 3'd6,
    CMD_POP   = 3'd7
  } pcs_cmd_e;
endpackage

// File: rtl/pcs_pc_next.sv
module pcs_pc_next
  import pcs_pkg::*;
#(
  parameter int PC_W     = 15,
  parameter int PAGE_W   = 12,
  parameter int DISP_W   = 7,
  parameter int LEN_W    = 2,
  parameter int VB       = 8,
  parameter int DISP_MIN = -31,
  parameter int DISP_MAX = 32
) (
  input  logic [PC_W-1:0]   pc_cur,
  input  pcs_cmd_e          op,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [PC_W-1:0]   jmp_imm,
  input  logic [DISP_W-1:0] disp,
  input  logic [VB-1:0]     vec_hi,
  input  logic [VB-1:0]     vec_lo,
  output logic [PC_W-1:0]   pc_nxt,
  output logic              disp_bad
);
  localparam logic signed [DISP_W-1:0] D_MIN = DISP_W'(DISP_MIN);
  localparam logic signed [DISP_W-1:0] D_MAX = DISP_W'(DISP_MAX);
  localparam logic signed [DISP_W-1:0] D_ONE = DISP_W'(1);

  logic [PC_W-1:0] pc_seq, pc_rel, pc_page, pc_vec, disp_ext;
  logic            disp_ok;

  always_comb begin
    pc_seq   = pc_cur + PC_W'(instr_len);
    disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    pc_rel   = pc_cur + disp_ext;
    pc_page  = {pc_cur[PC_W-1:PAGE_W], jmp_imm[PAGE_W-1:0]};
    pc_vec   = PC_W'({vec_hi, vec_lo});
    disp_ok  = ($signed(disp) >= D_MIN) && ($signed(disp) <= D_MAX)
             && ($signed(disp) != D_ONE);
    disp_bad = (op == CMD_JREL) && !disp_ok;
    unique case (op)
      CMD_HOLD:  pc_nxt = pc_cur;
      CMD_JLONG: pc_nxt = jmp_imm;
      CMD_JPAGE: pc_nxt = pc_page;
      CMD_JREL:  pc_nxt = disp_ok ? pc_rel : pc_seq;
      CMD_VECT:  pc_nxt = pc_vec;
      default:   pc_nxt = pc_seq;
    endcase
  end
endmodule

// File: rtl/pcs_stack_ctl.sv
module pcs_stack_ctl
  import pcs_pkg::*;
#(
  parameter int SP_W   = 8,
  parameter int DW     = 8,
  parameter int SP_RST = 'h6F
) (
  input  logic            clk,
  input  logic            rst,
  input  pcs_cmd_e        op,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   mem_rdata,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] addr_q,
  output logic [DW-1:0]   wdata_q,
  output logic            we_q,
  output logic [DW-1:0]   pdata_q,
  output logic            pvalid_q
);
  localparam logic [SP_W-1:0] SP_INIT = SP_W'(SP_RST);
  localparam logic [SP_W-1:0] SP_ONE  = SP_W'(1);

  logic rd_issued, rd_back;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= SP_INIT;
      addr_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      rd_issued <= 1'b0;
      rd_back   <= 1'b0;
      pvalid_q  <= 1'b0;
      pdata_q   <= '0;
    end else begin
      we_q      <= 1'b0;
      rd_issued <= (op == CMD_POP);
      rd_back   <= rd_issued;
      pvalid_q  <= rd_back;
      if (rd_back) pdata_q <= mem_rdata;
      if (op == CMD_PUSH) begin
        addr_q  <= sp_q;
        wdata_q <= acc_in;
        we_q    <= 1'b1;
        sp_q    <= sp_q - SP_ONE;
      end else if (op == CMD_POP) begin
        addr_q  <= sp_q + SP_ONE;
        sp_q    <= sp_q + SP_ONE;
      end
    end
  end
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
  import pcs_pkg::*;
#(
  parameter int PC_W     = 15,
  parameter int PAGE_W   = 12,
  parameter int DISP_W   = 7,
  parameter int LEN_W    = 2,
  parameter int SP_W     = 8,
  parameter int DW       = 8,
  parameter int VB       = 8,
  parameter int DISP_MIN = -31,
  parameter int DISP_MAX = 32,
  parameter int SP_RST   = 'h6F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [LEN_W-1:0]  instr_len,
  input  logic [PC_W-1:0]   jmp_imm,
  input  logic [DISP_W-1:0] disp,
  input  logic [VB-1:0]     vec_hi,
  input  logic [VB-1:0]     vec_lo,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     mem_rdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic [SP_W-1:0]   stk_addr,
  output logic [DW-1:0]     stk_wdata,
  output logic              stk_we,
  output logic [DW-1:0]     pop_data,
  output logic              pop_valid,
  output logic              bad_disp
);
  pcs_cmd_e        op;
  logic [PC_W-1:0] pc_q, pc_nxt;
  logic            disp_bad, bad_q;

  assign op = pcs_cmd_e'(cmd);

  pcs_pc_next #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .DISP_W(DISP_W), .LEN_W(LEN_W),
    .VB(VB), .DISP_MIN(DISP_MIN), .DISP_MAX(DISP_MAX)
  ) u_next (
    .pc_cur(pc_q), .op(op), .instr_len(instr_len), .jmp_imm(jmp_imm),
    .disp(disp), .vec_hi(vec_hi), .vec_lo(vec_lo),
    .pc_nxt(pc_nxt), .disp_bad(disp_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      bad_q <= 1'b0;
    end else begin
      pc_q  <= pc_nxt;
      bad_q <= disp_bad;
    end
  end

  pcs_stack_ctl #(.SP_W(SP_W), .DW(DW), .SP_RST(SP_RST)) u_stack (
    .clk(clk), .rst(rst), .op(op), .acc_in(acc_in), .mem_rdata(mem_rdata),
    .sp_q(sp), .addr_q(stk_addr), .wdata_q(stk_wdata), .we_q(stk_we),
    .pdata_q(pop_data), .pvalid_q(pop_valid)
  );

  assign pc       = pc_q;
  assign bad_disp = bad_q;
endmodule

// File: rtl/pcs_seq_chk.sv
module pcs_seq_chk
  import pcs_pkg::*;
#(
  parameter int PC_W   = 15,
  parameter int PAGE_W = 12,
  parameter int LEN_W  = 2,
  parameter int SP_W   = 8,
  parameter int DW     = 8,
  parameter int VB     = 8,
  parameter int SP_RST = 'h6F
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cmd,
  input logic [LEN_W-1:0] instr_len,
  input logic [PC_W-1:0]  jmp_imm,
  input logic [VB-1:0]    vec_hi,
  input logic [VB-1:0]    vec_lo,
  input logic [DW-1:0]    acc_in,
  input logic [DW-1:0]    mem_rdata,
  input logic [PC_W-1:0]  pc,
  input logic [SP_W-1:0]  sp,
  input logic [SP_W-1:0]  stk_addr,
  input logic [DW-1:0]    stk_wdata,
  input logic             stk_we,
  input logic [DW-1:0]    pop_data,
  input logic             pop_valid,
  input logic             bad_disp
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pc == '0 && sp == SP_W'(SP_RST) && !stk_we && !pop_valid && !bad_disp)); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_HOLD |=> ($stable(pc) && $stable(sp))); // R2
  AST_LONG_LOAD: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_JLONG |=> pc == $past(jmp_imm)); // R3
  AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_JPAGE |=> (pc[PC_W-1:PAGE_W] == $past(pc[PC_W-1:PAGE_W])
                          && pc[PAGE_W-1:0] == $past(jmp_imm[PAGE_W-1:0]))); // R4
  AST_BAD_STEP: assert property (@(posedge clk) disable iff (rst)
    bad_disp |-> pc == PC_W'($past(pc) + PC_W'($past(instr_len)))); // R6
  AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_VECT |=> pc == PC_W'({$past(vec_hi), $past(vec_lo)})); // R7
  AST_PUSH_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_PUSH |=> (stk_we && stk_addr == $past(sp) && stk_wdata == $past(acc_in)
                         && sp == SP_W'($past(sp) - SP_W'(1)))); // R8
  AST_POP_ADDR: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_POP |=> (!stk_we && sp == SP_W'($past(sp) + SP_W'(1)) && stk_addr == sp)); // R9
  AST_POP_RETURN: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> ($past(cmd, 3) == CMD_POP && pop_data == $past(mem_rdata))); // R9
endmodule

bind pc_stack_seq pcs_seq_chk #(
  .PC_W(PC_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W), .SP_W(SP_W), .DW(DW),
  .VB(VB), .SP_RST(SP_RST)
) i_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .instr_len(instr_len), .jmp_imm(jmp_imm),
  .vec_hi(vec_hi), .vec_lo(vec_lo), .acc_in(acc_in), .mem_rdata(mem_rdata),
  .pc(pc), .sp(sp), .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_we(stk_we),
  .pop_data(pop_data), .pop_valid(pop_valid), .bad_disp(bad_disp)
);

// File: tb/test_pc_stack_seq.sv
`timescale 1ns/1ps
module test_pc_stack_seq;
  import pcs_pkg::*;

  typedef struct {
    logic [14:0] pc;
    logic [7:0]  sp;
    logic        bad;
    logic        we;
    logic        chk_addr;
    logic [7:0]  addr;
    logic [7:0]  wdata;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  instr_len = 2'd1;
  logic [14:0] jmp_imm = '0;
  logic [6:0]  disp = '0;
  logic [7:0]  vec_hi = '0, vec_lo = '0, acc_in = '0, mem_rdata = '0;
  logic [14:0] pc;
  logic [7:0]  sp, stk_addr, stk_wdata, pop_data;
  logic        stk_we, pop_valid, bad_disp;

  int   n_chk = 0, n_fail = 0;
  bit   done = 0;
  exp_t sq[$];
  logic [7:0] popq[$];
  logic [7:0] ram [256];
  logic [7:0] m_mem [256];
  logic [14:0] m_pc = '0;
  logic [7:0]  m_sp = 8'h6F;

  always #2.5 clk = ~clk;

  pc_stack_seq i_pc_stack_seq (
    .clk(clk), .rst(rst), .cmd(cmd), .instr_len(instr_len), .jmp_imm(jmp_imm),
    .disp(disp), .vec_hi(vec_hi), .vec_lo(vec_lo), .acc_in(acc_in),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_we(stk_we), .pop_data(pop_data),
    .pop_valid(pop_valid), .bad_disp(bad_disp)
  );

  // synchronous stack RAM, one-cycle read latency
  always @(posedge clk) begin
    if (stk_we) ram[stk_addr] <= stk_wdata;
    mem_rdata <= ram[stk_addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // driver: drives one command and queues the state expected after the edge
  task automatic issue(input logic [2:0] c, input logic [1:0] len, input logic [14:0] imm,
                       input logic [6:0] d, input logic [7:0] vh, input logic [7:0] vl,
                       input logic [7:0] a, input string tag);
    exp_t e;
    int   sd;
    logic [14:0] seq_pc;
    seq_pc = m_pc + 15'(len);
    e.bad = 0; e.we = 0; e.chk_addr = 0; e.addr = '0; e.wdata = '0; e.tag = tag;
    case (c)
      3'd0: ;
      3'd1: m_pc = seq_pc;
      3'd2: m_pc = imm;
      3'd3: m_pc = {m_pc[14:12], imm[11:0]};
      3'd4: begin
        sd = $signed(d);
        if (sd >= -31 && sd <= 32 && sd != 1) m_pc = m_pc + 15'(sd);
        else begin m_pc = seq_pc; e.bad = 1; end
      end
      3'd5: m_pc = {vh[6:0], vl};
      3'd6: begin
        m_mem[m_sp] = a;
        e.we = 1; e.chk_addr = 1; e.addr = m_sp; e.wdata = a;
        m_sp = m_sp - 8'd1;
        m_pc = seq_pc;
      end
      default: begin
        m_sp = m_sp + 8'd1;
        e.chk_addr = 1; e.addr = m_sp;
        popq.push_back(m_mem[m_sp]);
        m_pc = seq_pc;
      end
    endcase
    e.pc = m_pc; e.sp = m_sp;
    @(negedge clk);
    cmd = c; instr_len = len; jmp_imm = imm; disp = d;
    vec_hi = vh; vec_lo = vl; acc_in = a;
    sq.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) issue(3'd0, 2'd1, '0, '0, '0, '0, '0, tag);
  endtask

  // monitor: compares outputs against the queued expectations after each edge
  always @(posedge clk) begin
    #1;
    if (sq.size() > 0) begin
      exp_t e;
      e = sq.pop_front();
      chk(pc == e.pc, {e.tag, " pc"}, pc, e.pc);
      chk(sp == e.sp, {e.tag, " sp"}, sp, e.sp);
      chk(bad_disp == e.bad, {e.tag, " bad_disp"}, bad_disp, e.bad);
      chk(stk_we == e.we, {e.tag, " stk_we"}, stk_we, e.we);
      if (e.chk_addr) chk(stk_addr == e.addr, {e.tag, " stk_addr"}, stk_addr, e.addr);
      if (e.we) chk(stk_wdata == e.wdata, {e.tag, " stk_wdata"}, stk_wdata, e.wdata);
    end
    if (pop_valid) begin
      if (popq.size() == 0) chk(0, "R9 unexpected pop_valid", 1, 0);
      else begin
        logic [7:0] x;
        x = popq.pop_front();
        chk(pop_data == x, "R9 pop_data", pop_data, x);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = '0; m_mem[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: state held during reset
    chk(pc == 15'd0 && sp == 8'h6F, "R1 in reset", {pc, sp}, {15'd0, 8'h6F});
    rst = 1'b0;
    @(posedge clk); #1;
    chk(pc == 15'd0 && sp == 8'h6F && !stk_we && !pop_valid && !bad_disp,
        "R1 after reset", {pc, sp}, {15'd0, 8'h6F});
    // R2 step lengths and hold
    issue(3'd1, 2'd1, '0, '0, '0, '0, '0, "R2 step1");
    issue(3'd1, 2'd2, '0, '0, '0, '0, '0, "R2 step2");
    issue(3'd1, 2'd3, '0, '0, '0, '0, '0, "R2 step3");
    idle(2, "R2 hold");
    // R3 long jump, R4 page jump
    issue(3'd2, 2'd1, 15'h7ABC, '0, '0, '0, '0, "R3 long");
    issue(3'd3, 2'd1, 15'h0123, '0, '0, '0, '0, "R4 page");
    issue(3'd3, 2'd1, 15'h5FFF, '0, '0, '0, '0, "R4 page upper ignored");
    // R5 legal relative jumps, edges of the window
    issue(3'd4, 2'd1, '0, 7'(-31), '0, '0, '0, "R5 rel -31");
    issue(3'd4, 2'd1, '0, 7'd32, '0, '0, '0, "R5 rel +32");
    issue(3'd4, 2'd1, '0, 7'd2, '0, '0, '0, "R5 rel +2");
    issue(3'd4, 2'd1, '0, 7'd0, '0, '0, '0, "R5 rel 0");
    // R6 illegal displacements
    issue(3'd4, 2'd2, '0, 7'd1, '0, '0, '0, "R6 rel +1");
    issue(3'd4, 2'd3, '0, 7'd33, '0, '0, '0, "R6 rel +33");
    issue(3'd4, 2'd1, '0, 7'(-32), '0, '0, '0, "R6 rel -32");
    issue(3'd1, 2'd1, '0, '0, '0, '0, '0, "R6 flag drops");
    // R7 vector
    issue(3'd5, 2'd1, '0, '0, 8'hD2, 8'h34, '0, "R7 vector");
    // R2/R5 PC wrap both directions
    issue(3'd2, 2'd1, 15'h7FFF, '0, '0, '0, '0, "R3 long top");
    issue(3'd1, 2'd2, '0, '0, '0, '0, '0, "R2 step wrap");
    issue(3'd2, 2'd1, 15'h0000, '0, '0, '0, '0, "R3 long zero");
    issue(3'd4, 2'd1, '0, 7'(-5), '0, '0, '0, "R5 rel wrap");
    // R8 pushes, R9 pops returning the pushed bytes
    issue(3'd6, 2'd1, '0, '0, '0, '0, 8'hA5, "R8 push a");
    issue(3'd6, 2'd1, '0, '0, '0, '0, 8'h3C, "R8 push b");
    issue(3'd7, 2'd1, '0, '0, '0, '0, '0, "R9 pop b");
    issue(3'd7, 2'd1, '0, '0, '0, '0, '0, "R9 pop a");
    idle(4, "R9 drain");
    // R10 walk sp upward through 0xFF -> 0x00, then push back across the wrap
    while (m_sp != 8'hFE) issue(3'd7, 2'd1, '0, '0, '0, '0, '0, "R10 pop walk");
    issue(3'd7, 2'd1, '0, '0, '0, '0, '0, "R10 pop to FF");
    issue(3'd7, 2'd1, '0, '0, '0, '0, '0, "R10 pop wrap to 00");
    issue(3'd6, 2'd1, '0, '0, '0, '0, 8'h77, "R10 push wrap to FF");
    issue(3'd7, 2'd1, '0, '0, '0, '0, '0, "R10 pop across wrap");
    idle(5, "R10 drain");
    chk(popq.size() == 0, "R9 all pops returned", popq.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end
endmodule